// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block sits between the external interrupt pins of a processor and its interrupt logic. It takes one non-maskable interrupt pin and eight general request pins, brings every pin into the core clock domain, and turns them into clean requests. The non-maskable pin is edge-detected on a selectable polarity. A detected event is latched as pending and offered to the CPU, either at once or only once the CPU's block bit is clear. The CPU removes the pending event with a one-cycle acknowledge.

The eight request pins form two groups of four. Each group is switched at run time, from a control register, between two modes. In the first, the four pins carry one active-low encoded priority level. In the second, they are four independent active-low request lines. The control register is 32 bits wide and read/write. Only four bits are implemented, and all of them reset to 0.

Top module: `irq_pin_front`

## Requirements
- R1: After reset the control register reads 0, and `nmi_req`, `ctx_lost`, `req_level` and `req_flags` are all 0 while the pins idle high.
- R2: With control bit 24 at 0, a falling edge on `nmi_pin` raises `nmi_req` on the third rising clock edge after the pin changes, and not before.
- R3: With control bit 24 at 1, a rising edge on `nmi_pin` is detected with the same latency, and a falling edge is ignored.
- R4: With control bit 25 at 0, a pending event keeps `nmi_req` low while `cpu_block` is 1. `nmi_req` rises in the same cycle that `cpu_block` returns to 0.
- R5: With control bit 25 at 1, `nmi_req` is driven while `cpu_block` is 1. If `nmi_ack` is taken while `nmi_req` and `cpu_block` are both 1, `ctx_lost` is high for exactly the one cycle after that acknowledge.
- R6: A one-cycle `nmi_ack` clears the pending event. Several edges that arrive while an event is pending merge into it, so a single acknowledge leaves `nmi_req` low.
- R7: With control bit 23 at 0, group 0 (pins 3..0) is encoded: `req_level[3:0]` is the bitwise inverse of the synchronised pins and `req_flags[3:0]` is 0.
- R8: With control bit 23 at 1, group 0 is independent: `req_flags[3:0]` is the inverse of the synchronised pins and `req_level[3:0]` is 0.
- R9: Control bit 22 selects the mode of group 1 (pins 7..4, `req_level[7:4]`, `req_flags[7:4]`) in the same way, independently of group 0.
- R10: Writing a new value to control bit 24 while the pin is steady produces no request.
- R11: Control bits 25..22 read back as written, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl_rdata | output | 32 | Control register read data |
| nmi_pin | input | 1 | Asynchronous non-maskable interrupt pin |
| req_pins | input | 8 | Asynchronous request pins, active low |
| cpu_block | input | 1 | CPU block bit |
| nmi_ack | input | 1 | One-cycle acknowledge of the pending event |
| nmi_req | output | 1 | Non-maskable request to the CPU |
| ctx_lost | output | 1 | Pulse: event accepted while blocked |
| req_level | output | 8 | Encoded levels, group 1 in [7:4] and group 0 in [3:0] |
| req_flags | output | 8 | Independent request flags, one per pin |

## Verification
The assertions assume that `nmi_ack` is raised for a single cycle, and only while `nmi_req` is high. They also assume that `cpu_block` is a level and not a pulse. The stimulus changes every input on the falling clock edge. It holds each pin value for at least three cycles, so that every change passes the synchroniser, and it acknowledges only after it has seen `nmi_req` high.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
  localparam int CTRL_W      = 32;
  localparam int BIT_NOHOLD  = 25;
  localparam int BIT_RISE    = 24;
  localparam int BIT_GRP0    = 23;
  localparam int NUM_GROUPS  = 2;
  localparam int GRP_PINS    = 4;
  localparam int NUM_PINS    = NUM_GROUPS * GRP_PINS;

  typedef struct packed {
    logic                  no_hold;
    logic                  rise_sel;
    logic [NUM_GROUPS-1:0] indep;
  } ctrl_t;
endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d_async;
      stage2 <= stage1;
    end
  end

  assign q_sync = stage2;
endmodule

// File: rtl/irqfe_ctrl.sv
module irqfe_ctrl
  import irqfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output irqfe_pkg::ctrl_t  ctrl,
  output logic              polarity_change
);
  irqfe_pkg::ctrl_t cfg_q;
  irqfe_pkg::ctrl_t cfg_d;

  always_comb begin
    cfg_d.no_hold  = wdata[BIT_NOHOLD];
    cfg_d.rise_sel = wdata[BIT_RISE];
    for (int g = 0; g < NUM_GROUPS; g++) begin
      cfg_d.indep[g] = wdata[BIT_GRP0 - g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata = '0;
    rdata[BIT_NOHOLD] = cfg_q.no_hold;
    rdata[BIT_RISE]   = cfg_q.rise_sel;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      rdata[BIT_GRP0 - g] = cfg_q.indep[g];
    end
  end

  assign ctrl            = cfg_q;
  assign polarity_change = we && (cfg_d.rise_sel != cfg_q.rise_sel);
endmodule

// File: rtl/irqfe_nmi.sv
module irqfe_nmi (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_sync,
  input  logic rise_sel,
  input  logic no_hold,
  input  logic polarity_change,
  input  logic cpu_block,
  input  logic ack,
  output logic req,
  output logic ctx_lost
);
  logic active_now;
  logic active_prev;
  logic hist_ok;
  logic edge_hit;
  logic pending;

  // Map the pin to an "active" level so one rising detector serves both polarities.
  assign active_now = rise_sel ? pin_sync : ~pin_sync;
  assign edge_hit   = hist_ok && active_now && !active_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_prev <= 1'b0;
      hist_ok     <= 1'b0;
    end else begin
      active_prev <= active_now;
      hist_ok     <= !polarity_change;
    end
  end

  // A new edge wins over a same-cycle acknowledge; edges while pending merge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (edge_hit) pending <= 1'b1;
    else if (ack)      pending <= 1'b0;
  end

  assign req = pending && (!cpu_block || no_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctx_lost <= 1'b0;
    else        ctx_lost <= ack && req && cpu_block;
  end
endmodule

// File: rtl/irqfe_group.sv
module irqfe_group #(
  parameter int PINS = 4
) (
  input  logic [PINS-1:0] pins_sync,
  input  logic            indep,
  output logic [PINS-1:0] level,
  output logic [PINS-1:0] flags
);
  logic [PINS-1:0] asserted;

  assign asserted = ~pins_sync;
  assign level    = indep ? '0 : asserted;
  assign flags    = indep ? asserted : '0;
endmodule

// File: rtl/irq_pin_front.sv
module irq_pin_front
  import irqfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  output logic [CTRL_W-1:0] ctrl_rdata,
  input  logic              nmi_pin,
  input  logic [NUM_PINS-1:0] req_pins,
  input  logic              cpu_block,
  input  logic              nmi_ack,
  output logic              nmi_req,
  output logic              ctx_lost,
  output logic [NUM_PINS-1:0] req_level,
  output logic [NUM_PINS-1:0] req_flags
);
  irqfe_pkg::ctrl_t     cfg;
  logic                 pol_chg;
  logic                 nmi_s;
  logic [NUM_PINS-1:0]  pins_s;

  irqfe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .rdata(ctrl_rdata), .ctrl(cfg), .polarity_change(pol_chg)
  );

  irqfe_sync #(.W(1), .RST_VAL(1'b1)) u_sync_nmi (
    .clk(clk), .rst_n(rst_n), .d_async(nmi_pin), .q_sync(nmi_s)
  );

  irqfe_sync #(.W(NUM_PINS), .RST_VAL({NUM_PINS{1'b1}})) u_sync_req (
    .clk(clk), .rst_n(rst_n), .d_async(req_pins), .q_sync(pins_s)
  );

  irqfe_nmi u_nmi (
    .clk(clk), .rst_n(rst_n), .pin_sync(nmi_s), .rise_sel(cfg.rise_sel),
    .no_hold(cfg.no_hold), .polarity_change(pol_chg), .cpu_block(cpu_block),
    .ack(nmi_ack), .req(nmi_req), .ctx_lost(ctx_lost)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irqfe_group #(.PINS(GRP_PINS)) u_grp (
      .pins_sync(pins_s[g*GRP_PINS +: GRP_PINS]),
      .indep(cfg.indep[g]),
      .level(req_level[g*GRP_PINS +: GRP_PINS]),
      .flags(req_flags[g*GRP_PINS +: GRP_PINS])
    );
  end
endmodule

// File: rtl/irq_pin_front_chk.sv
module irq_pin_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_block,
  input logic        nmi_ack,
  input logic        nmi_req,
  input logic        ctx_lost,
  input logic [31:0] ctrl_rdata,
  input logic [7:0]  req_level,
  input logic [7:0]  req_flags
);
  assert_held_while_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[25] && cpu_block) |-> !nmi_req);

  assert_ctx_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_lost |-> $past(nmi_ack && nmi_req && cpu_block));

  assert_grp0_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[23] |-> (req_flags[3:0] == 4'h0));

  assert_grp0_indep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[23] |-> (req_level[3:0] == 4'h0));

  assert_grp1_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[22] ? (req_level[7:4] == 4'h0) : (req_flags[7:4] == 4'h0));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[31:26] == 6'h0) && (ctrl_rdata[21:0] == 22'h0));
endmodule

bind irq_pin_front irq_pin_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_block(cpu_block), .nmi_ack(nmi_ack),
  .nmi_req(nmi_req), .ctx_lost(ctx_lost), .ctrl_rdata(ctrl_rdata),
  .req_level(req_level), .req_flags(req_flags)
);

// File: tb/irq_pin_front_tb_top.sv
`timescale 1ns/1ps
module irq_pin_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic        nmi_pin = 1'b1;
  logic [7:0]  req_pins = 8'hFF;
  logic        cpu_block = 1'b0;
  logic        nmi_ack = 1'b0;
  logic        nmi_req;
  logic        ctx_lost;
  logic [7:0]  req_level;
  logic [7:0]  req_flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  irq_pin_front dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .nmi_pin(nmi_pin), .req_pins(req_pins),
    .cpu_block(cpu_block), .nmi_ack(nmi_ack), .nmi_req(nmi_req),
    .ctx_lost(ctx_lost), .req_level(req_level), .req_flags(req_flags)
  );

  typedef struct packed {
    logic [1:0] mode;   // [1] group1 independent, [0] group0 independent
    logic [7:0] pins;
    logic [3:0] lvl0;
    logic [3:0] lvl1;
    logic [7:0] flags;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 8'hFF, 4'h0, 4'h0, 8'h00},
    '{2'b00, 8'h5A, 4'h5, 4'hA, 8'h00},
    '{2'b01, 8'h5A, 4'h0, 4'hA, 8'h05},
    '{2'b10, 8'h30, 4'hF, 4'h0, 8'hC0},
    '{2'b11, 8'h96, 4'h0, 4'h0, 8'h69},
    '{2'b00, 8'h00, 4'hF, 4'hF, 8'h00}
  };

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk);
    nmi_ack = 1'b1;
    step(1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    step(3);
    @(negedge clk) rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1 ctrl", ctrl_rdata, 32'h0);
    check("R1 nmi_req", {31'h0, nmi_req}, 32'h0);
    check("R1 ctx_lost", {31'h0, ctx_lost}, 32'h0);
    check("R1 level", {24'h0, req_level}, 32'h0);
    check("R1 flags", {24'h0, req_flags}, 32'h0);

    // R7 R8 R9 table walk
    for (int i = 0; i < NV; i++) begin
      wr((32'(TBL[i].mode[0]) << 23) | (32'(TBL[i].mode[1]) << 22));
      req_pins = TBL[i].pins;
      step(3);
      check("R7_R8 grp0 level", {28'h0, req_level[3:0]}, {28'h0, TBL[i].lvl0});
      check("R9 grp1 level", {28'h0, req_level[7:4]}, {28'h0, TBL[i].lvl1});
      check("R8_R9 flags", {24'h0, req_flags}, {24'h0, TBL[i].flags});
    end
    @(negedge clk) req_pins = 8'hFF;
    wr(32'h0);
    step(3);

    // R2 falling edge, latency
    @(negedge clk) nmi_pin = 1'b0;
    step(2);
    check("R2 not before 3rd edge", {31'h0, nmi_req}, 32'h0);
    step(1);
    check("R2 falling edge", {31'h0, nmi_req}, 32'h1);
    ack_pulse();
    @(negedge clk) nmi_ack = 1'b0;
    check("R6 ack clears", {31'h0, nmi_req}, 32'h0);

    // R3 rising edge select
    wr(32'h0100_0000);
    step(2);
    @(negedge clk) nmi_pin = 1'b1;
    step(3);
    check("R3 rising edge", {31'h0, nmi_req}, 32'h1);
    ack_pulse();
    @(negedge clk) nmi_ack = 1'b0;
    nmi_pin = 1'b0;
    step(5);
    check("R3 falling ignored", {31'h0, nmi_req}, 32'h0);

    // R10 polarity change with steady pin (pin low, back to falling)
    wr(32'h0);
    step(5);
    check("R10 no false edge", {31'h0, nmi_req}, 32'h0);

    // R4 held while blocked
    @(negedge clk) cpu_block = 1'b1; nmi_pin = 1'b1;
    step(4);
    @(negedge clk) nmi_pin = 1'b0;
    step(5);
    check("R4 held", {31'h0, nmi_req}, 32'h0);
    @(negedge clk) cpu_block = 1'b0;
    #1;
    check("R4 released", {31'h0, nmi_req}, 32'h1);
    ack_pulse();
    @(negedge clk) nmi_ack = 1'b0;

    // R5 delivered through block, context-loss pulse
    wr(32'h0200_0000);
    @(negedge clk) cpu_block = 1'b1; nmi_pin = 1'b1;
    step(4);
    @(negedge clk) nmi_pin = 1'b0;
    step(4);
    check("R5 through block", {31'h0, nmi_req}, 32'h1);
    check("R5 no pulse before ack", {31'h0, ctx_lost}, 32'h0);
    ack_pulse();
    check("R5 ctx pulse", {31'h0, ctx_lost}, 32'h1);
    @(negedge clk) nmi_ack = 1'b0;
    step(1);
    check("R5 pulse one cycle", {31'h0, ctx_lost}, 32'h0);
    @(negedge clk) cpu_block = 1'b0;

    // R6 merged edges
    @(negedge clk) nmi_pin = 1'b1;
    step(4);
    @(negedge clk) nmi_pin = 1'b0;
    step(4);
    @(negedge clk) nmi_pin = 1'b1;
    step(4);
    @(negedge clk) nmi_pin = 1'b0;
    step(4);
    check("R6 pending", {31'h0, nmi_req}, 32'h1);
    ack_pulse();
    @(negedge clk) nmi_ack = 1'b0;
    step(4);
    check("R6 merged single ack", {31'h0, nmi_req}, 32'h0);

    // R11 register mask
    wr(32'hFFFF_FFFF);
    #1;
    check("R11 readback", ctrl_rdata, 32'h03C0_0000);
    wr(32'h0280_0000);
    #1;
    check("R11 partial", ctrl_rdata, 32'h0280_0000);

    done = 1;
    finish_run();
  end
endmodule